// File: doc/BRIEF.md
# I2C Master Bit Engine

This block is the lowest layer of an I2C master. It drives the clock and data lines in open-drain fashion and runs one bus primitive per command: bus recovery, start condition, stop condition, byte write with acknowledge sampling, or byte read with a chosen acknowledge level. A higher-level controller builds whole transactions from these primitives. That controller also handles clock stretching and arbitration, which this block does not do.

Every bus phase is a fixed number of delay units. A delay unit is `UNIT_CLKS` system clocks, roughly a quarter of an SCL period. The engine holds each line at a fixed level for a whole number of units, then moves to the next phase. The data line is read back through a synchronizer, so a released line reads as 1. Commands arrive on a request/grant handshake. `busy` stays high from acceptance until the last phase ends, and `done` then pulses for one cycle.

Top module: `i2c_bit_engine`

## Requirements
- R1: After synchronous reset, both line drive enables are low (lines released), and `busy` and `done` are low.
- R2: `gnt` is high exactly when `req` is high, `busy` is low and `op` is a defined code: 0 recover, 1 start, 2 stop, 3 write, 4 read. Codes 5 to 7 are never granted and start nothing. `busy` is high in the cycle after a grant.
- R3: `busy` stays high for exactly N×`UNIT_CLKS` cycles after a grant, where N is 40 for recover, 3 for start, 4 for stop, 37 for write and 29 for read. `done` is high for one cycle as `busy` falls.
- R4: A start command releases SDA and SCL, then pulls SDA low while SCL stays released. It ends with SCL released and SDA low.
- R5: A stop command pulls SCL low, then SDA low, then releases SCL, then releases SDA while SCL is released. It gives exactly one SCL rising edge and ends with both lines released.
- R6: A write command puts `tx_byte` on SDA MSB first over eight SCL pulses. SDA changes only while SCL is low.
- R7: After the eighth written bit, the engine releases SDA for a ninth SCL pulse. It samples SDA in that pulse and reports the sample on `rx_nack` (1 = not acknowledged).
- R8: A read command releases SDA for eight SCL pulses and collects the bits sampled while SCL is high, MSB first, into `rx_byte`.
- R9: After the eighth read bit, SDA is driven low on the ninth SCL pulse if `tx_ack` was 0, and left released if it was 1.
- R10: Recovery keeps SDA released for nine SCL pulses and then performs a stop. That is ten SCL rising edges in total, ending with both lines released.
- R11: `rx_byte` and `rx_nack` change only in the cycle where `done` is high. A write leaves `rx_byte` unchanged and a read leaves `rx_nack` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Command request |
| op | input | 3 | Command code |
| tx_byte | input | 8 | Byte to write |
| tx_ack | input | 1 | Acknowledge level to send after a read (0 = ACK) |
| sda_in | input | 1 | Sensed SDA line level |
| gnt | output | 1 | Command accepted this cycle |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| rx_byte | output | 8 | Last byte read |
| rx_nack | output | 1 | Last sampled write acknowledge (1 = NACK) |
| scl_drive_low | output | 1 | Pull SCL low when high |
| sda_drive_low | output | 1 | Pull SDA low when high |

## Verification
Several properties are checked on every cycle: SDA stays unchanged while SCL is released inside byte and acknowledge phases, SDA stays released during recovery pulses, a grant is always followed by `busy`, `done` only ever closes a busy period, and the receive outputs move only with `done`. Some behaviour shows only in the bench scenarios, which use a responding slave model on the wired-AND data line. These are the exact phase durations, the order of bits on the wire, the start and stop conditions seen as line edges, the number of SCL pulses, and the value of sampled data and acknowledge bits.

// File: rtl/i2c_bit_pkg.sv
`timescale 1ns/1ps
package i2c_bit_pkg;

    typedef enum logic [2:0] {
        OP_RECOVER = 3'd0,
        OP_START   = 3'd1,
        OP_STOP    = 3'd2,
        OP_WRITE   = 3'd3,
        OP_READ    = 3'd4
    } bus_op_e;

    // Segment of a command: a short list of timed steps.
    typedef enum logic [2:0] {
        SG_START, SG_STOP, SG_WBIT, SG_WACK, SG_RBIT, SG_RACK, SG_PULSE
    } seg_e;

    typedef enum logic [1:0] {
        LN_KEEP, LN_LOW, LN_REL
    } line_act_e;

    typedef struct packed {
        line_act_e  scl;
        line_act_e  sda;
        logic [1:0] units;
        logic       sample;
        logic       last;
    } step_t;

    function automatic logic op_known(input logic [2:0] code);
        return code <= 3'd4;
    endfunction

    function automatic line_act_e level_act(input logic b);
        return b ? LN_REL : LN_LOW;
    endfunction

    function automatic step_t mk(input line_act_e c, input line_act_e d,
                                 input logic [1:0] u, input logic s, input logic l);
        step_t st;
        st.scl = c; st.sda = d; st.units = u; st.sample = s; st.last = l;
        return st;
    endfunction

    // Step table: line actions applied on entry, then a wait of 'units' delay units.
    function automatic step_t step_of(input seg_e sg, input logic [1:0] idx,
                                      input logic dbit, input logic abit);
        step_t st;
        st = mk(LN_KEEP, LN_KEEP, 2'd1, 1'b0, 1'b1);
        case (sg)
            SG_START: case (idx)
                2'd0:    st = mk(LN_KEEP, LN_KEEP, 2'd1, 1'b0, 1'b0);
                2'd1:    st = mk(LN_REL,  LN_REL,  2'd1, 1'b0, 1'b0);
                default: st = mk(LN_REL,  LN_LOW,  2'd1, 1'b0, 1'b1);
            endcase
            SG_STOP: case (idx)
                2'd0:    st = mk(LN_LOW,  LN_KEEP, 2'd1, 1'b0, 1'b0);
                2'd1:    st = mk(LN_KEEP, LN_LOW,  2'd1, 1'b0, 1'b0);
                2'd2:    st = mk(LN_REL,  LN_KEEP, 2'd1, 1'b0, 1'b0);
                default: st = mk(LN_KEEP, LN_REL,  2'd1, 1'b0, 1'b1);
            endcase
            SG_WBIT: case (idx)
                2'd0:    st = mk(LN_LOW,  LN_KEEP,         2'd1, 1'b0, 1'b0);
                2'd1:    st = mk(LN_KEEP, level_act(dbit), 2'd1, 1'b0, 1'b0);
                default: st = mk(LN_REL,  LN_KEEP,         2'd2, 1'b0, 1'b1);
            endcase
            SG_WACK: case (idx)
                2'd0:    st = mk(LN_LOW,  LN_KEEP, 2'd1, 1'b0, 1'b0);
                2'd1:    st = mk(LN_KEEP, LN_REL,  2'd1, 1'b0, 1'b0);
                2'd2:    st = mk(LN_REL,  LN_KEEP, 2'd2, 1'b1, 1'b0);
                default: st = mk(LN_LOW,  LN_KEEP, 2'd1, 1'b0, 1'b1);
            endcase
            SG_RBIT: case (idx)
                2'd0:    st = mk(LN_LOW,  LN_REL,  2'd1, 1'b0, 1'b0);
                2'd1:    st = mk(LN_REL,  LN_KEEP, 2'd1, 1'b1, 1'b0);
                default: st = mk(LN_KEEP, LN_KEEP, 2'd1, 1'b0, 1'b1);
            endcase
            SG_RACK: case (idx)
                2'd0:    st = mk(LN_LOW,  LN_KEEP,         2'd1, 1'b0, 1'b0);
                2'd1:    st = mk(LN_KEEP, level_act(abit), 2'd1, 1'b0, 1'b0);
                2'd2:    st = mk(LN_REL,  LN_KEEP,         2'd2, 1'b0, 1'b0);
                default: st = mk(LN_LOW,  LN_KEEP,         2'd1, 1'b0, 1'b1);
            endcase
            SG_PULSE: case (idx)
                2'd0:    st = mk(LN_LOW,  LN_REL,  2'd2, 1'b0, 1'b0);
                default: st = mk(LN_REL,  LN_KEEP, 2'd2, 1'b0, 1'b1);
            endcase
            default: st = mk(LN_KEEP, LN_KEEP, 2'd1, 1'b0, 1'b1);
        endcase
        return st;
    endfunction

endpackage

// File: rtl/i2c_line_sync.sv
`timescale 1ns/1ps
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] q;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) q[0] <= 1'b1;
                else     q[0] <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) q[g] <= 1'b1;
                else     q[g] <= q[g-1];
            end
        end
    end

    assign dout = q[STAGES-1];
endmodule

// File: rtl/i2c_unit_timer.sv
`timescale 1ns/1ps
module i2c_unit_timer #(
    parameter int UNIT_CLKS = 64
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  logic [1:0] units,
    output logic       expire
);
    localparam int CNT_W = (UNIT_CLKS > 1) ? $clog2(UNIT_CLKS) : 1;
    localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(UNIT_CLKS - 1);

    logic [CNT_W-1:0] cnt;
    logic [1:0]       left;

    // High in the final clock of the loaded wait.
    assign expire = (left == 2'd1) && (cnt == CNT_TOP);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            left <= 2'd0;
        end else if (load) begin
            cnt  <= '0;
            left <= units;
        end else if (left != 2'd0) begin
            if (cnt == CNT_TOP) begin
                cnt  <= '0;
                left <= left - 2'd1;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/i2c_step_seq.sv
`timescale 1ns/1ps
module i2c_step_seq
    import i2c_bit_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       accept,
    input  bus_op_e    op,
    input  logic [7:0] tx_byte,
    input  logic       tx_ack,
    input  logic       sda_s,
    input  logic       expire,
    output logic       tmr_load,
    output logic [1:0] tmr_units,
    output logic       busy,
    output logic       done,
    output logic       scl_oe,
    output logic       sda_oe,
    output logic [7:0] rx_byte,
    output logic       rx_nack
);
    seg_e       seg, nseg;
    logic [1:0] idx, nidx;
    logic [3:0] bitn, nbit;
    logic [7:0] tx_q, ntx;
    logic       ack_q;
    logic [7:0] rx_sh;
    logic       nack_q;
    step_t      cur, nstep;
    logic       advance, finish;

    always_comb begin
        cur     = step_of(seg, idx, tx_q[7], ack_q);
        nseg    = seg;
        nidx    = idx;
        nbit    = bitn;
        ntx     = tx_q;
        advance = 1'b0;
        finish  = 1'b0;
        if (accept) begin
            advance = 1'b1;
            nidx    = 2'd0;
            nbit    = 4'd0;
            ntx     = tx_byte;
            case (op)
                OP_RECOVER: nseg = SG_PULSE;
                OP_STOP:    nseg = SG_STOP;
                OP_WRITE:   nseg = SG_WBIT;
                OP_READ:    nseg = SG_RBIT;
                default:    nseg = SG_START;
            endcase
        end else if (busy && expire) begin
            if (!cur.last) begin
                advance = 1'b1;
                nidx    = idx + 2'd1;
            end else begin
                case (seg)
                    SG_WBIT: begin
                        advance = 1'b1;
                        nidx    = 2'd0;
                        ntx     = {tx_q[6:0], 1'b0};
                        if (bitn == 4'd7) nseg = SG_WACK;
                        else              nbit = bitn + 4'd1;
                    end
                    SG_RBIT: begin
                        advance = 1'b1;
                        nidx    = 2'd0;
                        if (bitn == 4'd7) nseg = SG_RACK;
                        else              nbit = bitn + 4'd1;
                    end
                    SG_PULSE: begin
                        advance = 1'b1;
                        nidx    = 2'd0;
                        if (bitn == 4'd8) nseg = SG_STOP;
                        else              nbit = bitn + 4'd1;
                    end
                    default: finish = 1'b1;
                endcase
            end
        end
        nstep     = step_of(nseg, nidx, ntx[7], accept ? tx_ack : ack_q);
        tmr_load  = advance;
        tmr_units = nstep.units;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            done    <= 1'b0;
            seg     <= SG_START;
            idx     <= 2'd0;
            bitn    <= 4'd0;
            tx_q    <= 8'd0;
            ack_q   <= 1'b0;
            rx_sh   <= 8'd0;
            nack_q  <= 1'b0;
            scl_oe  <= 1'b0;
            sda_oe  <= 1'b0;
            rx_byte <= 8'd0;
            rx_nack <= 1'b0;
        end else begin
            done <= finish;
            seg  <= nseg;
            idx  <= nidx;
            bitn <= nbit;
            tx_q <= ntx;
            if (accept) begin
                busy  <= 1'b1;
                ack_q <= tx_ack;
            end
            if (finish) begin
                busy <= 1'b0;
                if (seg == SG_WACK) rx_nack <= nack_q;
                if (seg == SG_RACK) rx_byte <= rx_sh;
            end
            if (busy && expire && cur.sample) begin
                if (seg == SG_WACK) nack_q <= sda_s;
                else                rx_sh  <= {rx_sh[6:0], sda_s};
            end
            if (advance) begin
                case (nstep.scl)
                    LN_LOW:  scl_oe <= 1'b1;
                    LN_REL:  scl_oe <= 1'b0;
                    default: scl_oe <= scl_oe;
                endcase
                case (nstep.sda)
                    LN_LOW:  sda_oe <= 1'b1;
                    LN_REL:  sda_oe <= 1'b0;
                    default: sda_oe <= sda_oe;
                endcase
            end
        end
    end

    // Data may move only while SCL is held low inside byte and acknowledge phases.
    assert_sda_steady_scl_high_R6: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && !scl_oe && !$past(scl_oe) &&
         (seg == SG_WBIT || seg == SG_WACK || seg == SG_RBIT || seg == SG_RACK))
        |-> $stable(sda_oe));

    // Recovery pulses never pull SDA.
    assert_recover_sda_free_R10: assert property (@(posedge clk) disable iff (rst)
        (busy && seg == SG_PULSE) |-> !sda_oe);

    // A completion pulse always ends a busy period.
    assert_done_closes_R3: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy)));

    // Receive outputs move only together with the completion pulse.
    assert_rx_hold_R11: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(rx_byte) && $stable(rx_nack)));
endmodule

// File: rtl/i2c_bit_engine.sv
`timescale 1ns/1ps
module i2c_bit_engine
    import i2c_bit_pkg::*;
#(
    parameter int UNIT_CLKS   = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       req,
    input  logic [2:0] op,
    input  logic [7:0] tx_byte,
    input  logic       tx_ack,
    input  logic       sda_in,
    output logic       gnt,
    output logic       busy,
    output logic       done,
    output logic [7:0] rx_byte,
    output logic       rx_nack,
    output logic       scl_drive_low,
    output logic       sda_drive_low
);
    logic       sda_s;
    logic       tmr_load;
    logic [1:0] tmr_units;
    logic       expire;

    assign gnt = req && !busy && op_known(op);

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (sda_in),
        .dout (sda_s)
    );

    i2c_unit_timer #(.UNIT_CLKS(UNIT_CLKS)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .load   (tmr_load),
        .units  (tmr_units),
        .expire (expire)
    );

    i2c_step_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .accept    (gnt),
        .op        (bus_op_e'(op)),
        .tx_byte   (tx_byte),
        .tx_ack    (tx_ack),
        .sda_s     (sda_s),
        .expire    (expire),
        .tmr_load  (tmr_load),
        .tmr_units (tmr_units),
        .busy      (busy),
        .done      (done),
        .scl_oe    (scl_drive_low),
        .sda_oe    (sda_drive_low),
        .rx_byte   (rx_byte),
        .rx_nack   (rx_nack)
    );

    assert_grant_launch_R2: assert property (@(posedge clk) disable iff (rst)
        gnt |=> busy);
endmodule

// File: tb/i2c_bit_engine_bench.sv
`timescale 1ns/1ps
module i2c_bit_engine_bench;
    localparam int D = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req = 1'b0;
    logic [2:0] op = 3'd0;
    logic [7:0] tx_byte = 8'd0;
    logic       tx_ack = 1'b0;
    logic       sda_in;
    logic       gnt, busy, done, rx_nack, scl_oe, sda_oe;
    logic [7:0] rx_byte;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    // Slave side of the wired-AND data line.
    logic       slave_low = 1'b0;
    assign sda_in = !(sda_oe || slave_low);

    i2c_bit_engine #(.UNIT_CLKS(D)) u_i2c_bit_engine (
        .clk(clk), .rst(rst), .req(req), .op(op), .tx_byte(tx_byte),
        .tx_ack(tx_ack), .sda_in(sda_in), .gnt(gnt), .busy(busy),
        .done(done), .rx_byte(rx_byte), .rx_nack(rx_nack),
        .scl_drive_low(scl_oe), .sda_drive_low(sda_oe)
    );

    // Bus monitor and responding slave.
    int         rises = 0, starts = 0, stops = 0, base = 0;
    logic       bitlog [256];
    logic       scl_p = 1'b1, sda_p = 1'b1;
    logic [2:0] mode = 3'd7;
    logic [7:0] sbyte = 8'd0;
    logic       sack = 1'b0;

    always @(negedge clk) begin
        logic scl_l, sda_l;
        int   rel;
        scl_l = !scl_oe;
        sda_l = sda_in;
        if (!scl_p && scl_l) begin
            bitlog[rises & 255] = sda_l;
            rises++;
        end
        if (scl_p && scl_l && sda_p && !sda_l) starts++;
        if (scl_p && scl_l && !sda_p && sda_l) stops++;
        scl_p = scl_l;
        sda_p = sda_l;
        rel = rises - base;
        if (!scl_l) begin
            if (mode == 3'd4 && rel < 8)       slave_low = !sbyte[3'(7 - rel)];
            else if (mode == 3'd3 && rel == 8) slave_low = !sack;
            else                               slave_low = 1'b0;
        end
    end

    task automatic chk(input bit ok, input string req_tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req_tag, act, exp);
        end
    endtask

    function automatic int exp_units(input int c);
        case (c)
            0: return 40;
            1: return 3;
            2: return 4;
            3: return 37;
            default: return 29;
        endcase
    endfunction

    logic [7:0] last_rx = 8'd0;
    logic       last_nack = 1'b0;

    task automatic run(input int c, input logic [7:0] b, input logic a);
        int n, r0, st0, sp0;
        @(negedge clk);
        mode = 3'(c); sbyte = b; sack = a;
        base = rises; r0 = rises; st0 = starts; sp0 = stops;
        req = 1'b1; op = 3'(c); tx_byte = b; tx_ack = a;
        #1;
        chk(gnt == 1'b1, "R2 grant", gnt, 1);
        @(negedge clk);
        req = 1'b0;
        n = 0;
        while (busy && n < 100000) begin
            n++;
            @(negedge clk);
        end
        chk(n == exp_units(c) * D, "R3 busy length", n, exp_units(c) * D);
        chk(done == 1'b1, "R3 done pulse", done, 1);
        case (c)
            0: begin
                chk(rises - r0 == 10, "R10 pulse count", rises - r0, 10);
                for (int i = 0; i < 9; i++)
                    chk(bitlog[(r0 + i) & 255] == 1'b1, "R10 sda released", bitlog[(r0 + i) & 255], 1);
                chk(stops - sp0 == 1 && !scl_oe && !sda_oe, "R10 final stop", stops - sp0, 1);
            end
            1: begin
                chk(starts - st0 == 1, "R4 start edge", starts - st0, 1);
                chk(!scl_oe && sda_oe, "R4 end lines", {scl_oe, sda_oe}, 2'b01);
            end
            2: begin
                chk(stops - sp0 == 1 && rises - r0 == 1, "R5 stop edge", stops - sp0, 1);
                chk(!scl_oe && !sda_oe, "R5 end lines", {scl_oe, sda_oe}, 0);
            end
            3: begin
                logic [7:0] seen;
                for (int i = 0; i < 8; i++) seen[7 - i] = bitlog[(r0 + i) & 255];
                chk(seen == b, "R6 bits on wire", seen, b);
                chk(rises - r0 == 9, "R7 ninth pulse", rises - r0, 9);
                chk(rx_nack == a, "R7 ack sample", rx_nack, a);
                chk(rx_byte == last_rx, "R11 rx_byte kept", rx_byte, last_rx);
                last_nack = a;
            end
            default: begin
                chk(rx_byte == b, "R8 read byte", rx_byte, b);
                chk(bitlog[(r0 + 8) & 255] == a, "R9 ack level", bitlog[(r0 + 8) & 255], a);
                chk(rx_nack == last_nack, "R11 rx_nack kept", rx_nack, last_nack);
                last_rx = b;
            end
        endcase
        mode = 3'd7;
    endtask

    initial begin
        #(5.0 * 150000);
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (4) @(negedge clk);
        chk(!scl_oe && !sda_oe && !busy && !done, "R1 reset state",
            {scl_oe, sda_oe, busy, done}, 0);
        rst = 1'b0;
        @(negedge clk);

        // Undefined command codes are refused.
        for (int k = 5; k < 8; k++) begin
            req = 1'b1; op = 3'(k);
            #1;
            chk(gnt == 1'b0, "R2 reject code", gnt, 0);
            repeat (3) @(negedge clk);
            chk(!busy && !scl_oe && !sda_oe, "R2 no activity", {busy, scl_oe, sda_oe}, 0);
            req = 1'b0;
        end

        run(0, 8'h00, 1'b0);
        run(1, 8'h00, 1'b0);
        run(3, 8'hA5, 1'b0);
        run(3, 8'h5A, 1'b1);
        run(1, 8'h00, 1'b0);
        run(4, 8'h3C, 1'b0);
        run(4, 8'hC3, 1'b1);
        run(2, 8'h00, 1'b0);
        run(1, 8'h00, 1'b0);
        run(4, 8'h00, 1'b0);
        run(3, 8'hFF, 1'b0);
        run(4, 8'hFF, 1'b1);
        run(2, 8'h00, 1'b0);

        // Random byte traffic framed by start and stop.
        for (int t = 0; t < 24; t++) begin
            int kind;
            if (t % 6 == 0) run(1, 8'h00, 1'b0);
            kind = ($urandom % 2 == 0) ? 3 : 4;
            run(kind, 8'($urandom), 1'($urandom));
            if (t % 6 == 5) run(2, 8'h00, 1'b0);
        end

        // Recovery from a held start (SCL released, SDA low).
        run(1, 8'h00, 1'b0);
        run(0, 8'h00, 1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule